// File: doc/BRIEF.md
# Flash Byte Program and Chip Erase Sequencer

This block sits on the host side of a byte-wide parallel flash device. It turns two user requests into the sequence of command-bus cycles that the flash needs. One request programs a single byte. The other erases the whole chip. The block drives chip-enable, write-enable, output-enable, the address and the write data toward the flash, and it samples the flash's read data during its own read cycles.

**Program request.** The sequencer arms the device for programming and writes the target address and byte. It then waits a fixed number of clock cycles and issues the program-verify command. It reads the byte back and compares it with the requested value. On a mismatch it programs the byte again, up to a configured limit.

**Erase request.** The sequencer first drives every location to 00h, using the same program-and-verify loop. It then issues the erase command pair and waits the erase settle time. After that it verifies each address for FFh. A failed address triggers another erase pulse, and verification resumes at that same address.

**End of every operation.** The sequencer writes the reset command twice, which leaves the device in read mode. It then reports completion with a one-cycle done pulse. An error flag accompanies that pulse when a retry limit was exceeded.

Top module: `flash_seq`

## Requirements
- R1: After reset and while idle, fl_ce_n, fl_we_n and fl_oe_n are high, and busy, done and err are low.
- R2: Every bus write holds fl_ce_n low around a write-enable pulse that is exactly WE_CYC clock cycles long. fl_addr and fl_dout stay stable while write-enable is low, and fl_we_n and fl_oe_n are never low together.
- R3: A byte program writes 40h, then writes the data byte at the target address. It then waits at least PROG_WAIT clock cycles before writing C0h, and then performs a read cycle at the target address.
- R4: When the read-back byte differs from the requested byte, the program sequence repeats. A byte gets at most PROG_TRIES attempts. If the last attempt also mismatches, the operation ends with err asserted.
- R5: A chip erase first programs every address from 0 to 2^AW-1 to 00h, using the R3/R4 sequence. This happens before the first erase pulse.
- R6: An erase pulse is two consecutive writes of 20h. At least ERASE_WAIT clock cycles pass after it before any A0h write.
- R7: Erase verify walks the addresses in ascending order. For each address it writes A0h with that address and then reads it. The address passes only on FFh.
- R8: A failed erase verify issues a new erase pulse, and verification resumes at the failing address, not at address 0. At most ERASE_TRIES erase pulses are issued. A failure after the last pulse ends the operation with err asserted.
- R9: Every operation ends with two writes of FFh, followed by a done pulse exactly one cycle wide. err is high only in that cycle, and only for a failed operation. busy stays high from acceptance until done.
- R10: Requests are taken only while idle; req_prog and req_erase raised while busy are ignored. If both are raised in the same idle cycle, the erase is performed and the program request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_prog | input | 1 | Start a single-byte program (sampled while idle) |
| req_erase | input | 1 | Start a full-chip erase (sampled while idle, wins over req_prog) |
| req_addr | input | AW | Byte address for a program request |
| req_data | input | 8 | Byte value for a program request |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Retry limit exceeded; valid only with done |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dout | output | 8 | Data driven toward the flash on writes |
| fl_din | input | 8 | Data returned by the flash during read cycles |

## Verification
The flash is modelled with AND-only programming, a bulk erase to FFh, and a cycle-stamped log of command writes. This lets the bench measure the program and erase waits and count every program, erase and verify-command write.

Program requests are tried three ways: a byte that programs at once, one whose first two program pulses are dropped, and one that never programs. Comparing the program-pulse counts across these cases separates correct retrying from premature success and from missing error reporting.

Erase requests are tried three ways: a clean erase, an erase where one address survives the first pulse, and an erase that never succeeds. The count of A0h writes after the retry shows whether verification resumed at the failing address or restarted at address 0.

Overlapping and simultaneous requests show that busy-time requests are ignored and that erase takes priority.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   // Command bytes understood by the flash command register
   localparam logic [7:0] CMD_PROG_ARM  = 8'h40;
   localparam logic [7:0] CMD_PROG_CHK  = 8'hC0;
   localparam logic [7:0] CMD_ERASE     = 8'h20;
   localparam logic [7:0] CMD_ERASE_CHK = 8'hA0;
   localparam logic [7:0] CMD_RESET     = 8'hFF;

   localparam logic [7:0] BYTE_CLEAR    = 8'h00;
   localparam logic [7:0] BYTE_BLANK    = 8'hFF;

   typedef enum logic [1:0] {
      BUS_IDLE,
      BUS_SETUP,
      BUS_STROBE,
      BUS_HOLD
   } bus_phase_t;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_P_ARM,
      SQ_P_WRITE,
      SQ_P_WAIT,
      SQ_P_CHKCMD,
      SQ_P_READ,
      SQ_E_ARM,
      SQ_E_FIRE,
      SQ_E_WAIT,
      SQ_E_CHKCMD,
      SQ_E_READ,
      SQ_X_FIRST,
      SQ_X_SECOND,
      SQ_FINISH
   } seq_state_t;

endpackage

// File: rtl/fseq_bus.sv
module fseq_bus
   import fseq_pkg::*;
#(
   parameter int AW     = 17,
   parameter int WE_CYC = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          rd,
   input  logic [AW-1:0] addr_in,
   input  logic [7:0]    data_in,
   output logic          fin,
   output logic [7:0]    rdata,
   output logic          ce_n,
   output logic          we_n,
   output logic          oe_n,
   output logic [AW-1:0] addr_o,
   output logic [7:0]    dout,
   input  logic [7:0]    din
);

   localparam int CW = $clog2(WE_CYC + 1);

   bus_phase_t    phase;
   logic [CW-1:0] cnt;
   logic          rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= BUS_IDLE;
         cnt    <= '0;
         rd_q   <= 1'b0;
         addr_o <= '0;
         dout   <= '0;
         rdata  <= '0;
      end else begin
         case (phase)
            BUS_IDLE: begin
               if (start) begin
                  rd_q   <= rd;
                  addr_o <= addr_in;
                  dout   <= data_in;
                  phase  <= BUS_SETUP;
               end
            end
            BUS_SETUP: begin
               cnt   <= CW'(WE_CYC - 1);
               phase <= BUS_STROBE;
            end
            BUS_STROBE: begin
               if (cnt == '0) begin
                  phase <= BUS_HOLD;
                  if (rd_q) rdata <= din;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: phase <= BUS_IDLE;
         endcase
      end
   end

   assign fin  = (phase == BUS_HOLD);
   assign ce_n = (phase == BUS_IDLE);
   assign we_n = !((phase == BUS_STROBE) && !rd_q);
   assign oe_n = !((phase == BUS_STROBE) && rd_q);

endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
   parameter int unsigned PROG_WAIT  = 1000,
   parameter int unsigned ERASE_WAIT = 950000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic sel_long,
   output logic expired
);

   localparam int unsigned LONGEST = (ERASE_WAIT > PROG_WAIT) ? ERASE_WAIT : PROG_WAIT;
   localparam int TW = $clog2(LONGEST + 1);

   logic [TW-1:0] cnt;
   logic          run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (start) begin
         run <= 1'b1;
         cnt <= sel_long ? TW'(ERASE_WAIT) : TW'(PROG_WAIT);
      end else if (run) begin
         if (cnt == '0) run <= 1'b0;
         else           cnt <= cnt - 1'b1;
      end
   end

   assign expired = run && (cnt == '0);

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
   import fseq_pkg::*;
#(
   parameter int AW          = 17,
   parameter int PROG_TRIES  = 25,
   parameter int ERASE_TRIES = 1000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_prog,
   input  logic          req_erase,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    req_data,
   output logic          bus_start,
   output logic          bus_rd,
   output logic [AW-1:0] bus_addr,
   output logic [7:0]    bus_data,
   input  logic          bus_fin,
   input  logic [7:0]    bus_rdata,
   output logic          tmr_start,
   output logic          tmr_long,
   input  logic          tmr_exp,
   output logic          busy,
   output logic          done,
   output logic          err
);

   localparam int PW = $clog2(PROG_TRIES + 1);
   localparam int EW = $clog2(ERASE_TRIES + 1);
   localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};

   seq_state_t    st;
   logic          pend;
   logic          whole_chip;
   logic [AW-1:0] cur;
   logic [7:0]    want;
   logic [PW-1:0] ptry;
   logic [EW-1:0] etry;
   logic          failed;
   logic          on_bus;

   // Bus request fields per state
   always_comb begin
      on_bus   = 1'b1;
      bus_rd   = 1'b0;
      bus_addr = cur;
      bus_data = CMD_RESET;
      case (st)
         SQ_P_ARM:    bus_data = CMD_PROG_ARM;
         SQ_P_WRITE:  bus_data = want;
         SQ_P_CHKCMD: bus_data = CMD_PROG_CHK;
         SQ_P_READ:   bus_rd   = 1'b1;
         SQ_E_ARM,
         SQ_E_FIRE:   bus_data = CMD_ERASE;
         SQ_E_CHKCMD: bus_data = CMD_ERASE_CHK;
         SQ_E_READ:   bus_rd   = 1'b1;
         SQ_X_FIRST,
         SQ_X_SECOND: bus_data = CMD_RESET;
         default:     on_bus   = 1'b0;
      endcase
   end

   assign bus_start = on_bus && !pend;
   assign tmr_start = bus_fin && ((st == SQ_P_WRITE) || (st == SQ_E_FIRE));
   assign tmr_long  = (st == SQ_E_FIRE);
   assign busy      = (st != SQ_IDLE);
   assign done      = (st == SQ_FINISH);
   assign err       = done && failed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= SQ_IDLE;
         pend       <= 1'b0;
         whole_chip <= 1'b0;
         cur        <= '0;
         want       <= '0;
         ptry       <= '0;
         etry       <= '0;
         failed     <= 1'b0;
      end else begin
         if (bus_start) pend <= 1'b1;
         else if (bus_fin) pend <= 1'b0;

         case (st)
            SQ_IDLE: begin
               ptry   <= '0;
               etry   <= '0;
               failed <= 1'b0;
               if (req_erase) begin
                  whole_chip <= 1'b1;
                  cur        <= '0;
                  want       <= BYTE_CLEAR;
                  st         <= SQ_P_ARM;
               end else if (req_prog) begin
                  whole_chip <= 1'b0;
                  cur        <= req_addr;
                  want       <= req_data;
                  st         <= SQ_P_ARM;
               end
            end
            SQ_P_ARM:    if (bus_fin) st <= SQ_P_WRITE;
            SQ_P_WRITE:  if (bus_fin) st <= SQ_P_WAIT;
            SQ_P_WAIT:   if (tmr_exp) st <= SQ_P_CHKCMD;
            SQ_P_CHKCMD: if (bus_fin) st <= SQ_P_READ;
            SQ_P_READ: begin
               if (bus_fin) begin
                  if (bus_rdata == want) begin
                     ptry <= '0;
                     if (!whole_chip) begin
                        st <= SQ_X_FIRST;
                     end else if (cur == LAST_ADDR) begin
                        cur <= '0;
                        st  <= SQ_E_ARM;
                     end else begin
                        cur <= cur + 1'b1;
                        st  <= SQ_P_ARM;
                     end
                  end else if (ptry == PW'(PROG_TRIES - 1)) begin
                     failed <= 1'b1;
                     st     <= SQ_X_FIRST;
                  end else begin
                     ptry <= ptry + 1'b1;
                     st   <= SQ_P_ARM;
                  end
               end
            end
            SQ_E_ARM:    if (bus_fin) st <= SQ_E_FIRE;
            SQ_E_FIRE:   if (bus_fin) st <= SQ_E_WAIT;
            SQ_E_WAIT:   if (tmr_exp) st <= SQ_E_CHKCMD;
            SQ_E_CHKCMD: if (bus_fin) st <= SQ_E_READ;
            SQ_E_READ: begin
               if (bus_fin) begin
                  if (bus_rdata == BYTE_BLANK) begin
                     if (cur == LAST_ADDR) begin
                        st <= SQ_X_FIRST;
                     end else begin
                        cur <= cur + 1'b1;
                        st  <= SQ_E_CHKCMD;
                     end
                  end else if (etry == EW'(ERASE_TRIES - 1)) begin
                     failed <= 1'b1;
                     st     <= SQ_X_FIRST;
                  end else begin
                     etry <= etry + 1'b1;
                     st   <= SQ_E_ARM;
                  end
               end
            end
            SQ_X_FIRST:  if (bus_fin) st <= SQ_X_SECOND;
            SQ_X_SECOND: if (bus_fin) st <= SQ_FINISH;
            default:     st <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
   parameter int AW          = 17,
   parameter int WE_CYC      = 4,
   parameter int PROG_WAIT   = 1000,
   parameter int ERASE_WAIT  = 950000,
   parameter int PROG_TRIES  = 25,
   parameter int ERASE_TRIES = 1000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_prog,
   input  logic          req_erase,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    req_data,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic          fl_ce_n,
   output logic          fl_we_n,
   output logic          fl_oe_n,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_dout,
   input  logic [7:0]    fl_din
);

   generate
      if (AW < 1 || AW > 30) begin : g_bad_aw
         $error("flash_seq: AW must lie in 1..30");
      end
      if (WE_CYC < 1) begin : g_bad_we
         $error("flash_seq: WE_CYC must be at least 1");
      end
      if (PROG_WAIT < 1 || ERASE_WAIT < 1) begin : g_bad_wait
         $error("flash_seq: wait times must be at least 1 cycle");
      end
      if (PROG_TRIES < 1 || ERASE_TRIES < 1) begin : g_bad_tries
         $error("flash_seq: retry limits must be at least 1");
      end
   endgenerate

   logic          bus_start, bus_rd, bus_fin;
   logic [AW-1:0] bus_addr;
   logic [7:0]    bus_data, bus_rdata;
   logic          tmr_start, tmr_long, tmr_exp;

   fseq_ctrl #(
      .AW(AW), .PROG_TRIES(PROG_TRIES), .ERASE_TRIES(ERASE_TRIES)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_prog(req_prog), .req_erase(req_erase),
      .req_addr(req_addr), .req_data(req_data),
      .bus_start(bus_start), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_fin(bus_fin), .bus_rdata(bus_rdata),
      .tmr_start(tmr_start), .tmr_long(tmr_long), .tmr_exp(tmr_exp),
      .busy(busy), .done(done), .err(err)
   );

   fseq_bus #(.AW(AW), .WE_CYC(WE_CYC)) u_bus (
      .clk(clk), .rst_n(rst_n),
      .start(bus_start), .rd(bus_rd),
      .addr_in(bus_addr), .data_in(bus_data),
      .fin(bus_fin), .rdata(bus_rdata),
      .ce_n(fl_ce_n), .we_n(fl_we_n), .oe_n(fl_oe_n),
      .addr_o(fl_addr), .dout(fl_dout), .din(fl_din)
   );

   fseq_timer #(
      .PROG_WAIT(PROG_WAIT), .ERASE_WAIT(ERASE_WAIT)
   ) u_timer (
      .clk(clk), .rst_n(rst_n),
      .start(tmr_start), .sel_long(tmr_long), .expired(tmr_exp)
   );

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
   parameter int AW     = 17,
   parameter int WE_CYC = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          err,
   input logic          fl_ce_n,
   input logic          fl_we_n,
   input logic          fl_oe_n,
   input logic [AW-1:0] fl_addr,
   input logic [7:0]    fl_dout
);

   localparam int LW = $clog2(WE_CYC + 2) + 1;

   logic [LW-1:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        low_run <= '0;
      else if (!fl_we_n) low_run <= low_run + 1'b1;
      else               low_run <= '0;
   end

   a_r1_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (fl_ce_n && fl_we_n && fl_oe_n));

   a_r2_we_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |-> !fl_ce_n);

   a_r2_no_we_oe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_we_n && !fl_oe_n));

   a_r2_addr_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));

   a_r2_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_we_n && $past(!fl_we_n)) |-> (low_run == LW'(WE_CYC)));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   a_r9_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

endmodule

bind flash_seq fseq_chk #(.AW(AW), .WE_CYC(WE_CYC)) u_chk (.*);

// File: tb/flash_seq_bench.sv
`timescale 1ns/1ps
module flash_seq_bench;

   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;
   localparam int WE    = 2;
   localparam int PW    = 20;
   localparam int EWT   = 200;
   localparam int PT    = 4;
   localparam int ET    = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_prog = 1'b0, req_erase = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_data = '0;
   logic          busy, done, err;
   logic          fl_ce_n, fl_we_n, fl_oe_n;
   logic [AW-1:0] fl_addr;
   logic [7:0]    fl_dout, fl_din;

   always #2.5 clk = ~clk;

   flash_seq #(
      .AW(AW), .WE_CYC(WE), .PROG_WAIT(PW), .ERASE_WAIT(EWT),
      .PROG_TRIES(PT), .ERASE_TRIES(ET)
   ) u_flash_seq (.*);

   int n_chk = 0, n_bad = 0;

   // ---------------- flash model ----------------
   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] lat_a;
   logic [7:0]    pend_cmd = 8'h00;
   int cyc = 0;
   int prog_ops, erase_ops, a0_cnt, ff_run, fail_prog, fail_erase, bad_a;
   int t_prog, t_erase, wait_viol, preprog_bad, strobe_bad, wl;
   logic [7:0] wd;

   assign fl_din = (!fl_ce_n && !fl_oe_n) ? mem[fl_addr] : 8'h00;

   always @(posedge clk) cyc++;

   always @(negedge fl_we_n) lat_a = fl_addr;

   always @(posedge fl_we_n) begin
      wd = fl_dout;
      if (wd == 8'hFF) ff_run++; else ff_run = 0;
      if (pend_cmd == 8'h40) begin
         prog_ops++;
         if (fail_prog > 0) fail_prog--;
         else mem[lat_a] = mem[lat_a] & wd;
         t_prog   = cyc;
         pend_cmd = 8'h00;
      end else if (pend_cmd == 8'h20 && wd == 8'h20) begin
         erase_ops++;
         for (int i = 0; i < DEPTH; i++) begin
            if (mem[i] != 8'h00) preprog_bad++;
            if (!(i == bad_a && fail_erase > 0)) mem[i] = 8'hFF;
         end
         if (fail_erase > 0) fail_erase--;
         t_erase  = cyc;
         pend_cmd = 8'h00;
      end else begin
         pend_cmd = (wd == 8'h40 || wd == 8'h20) ? wd : 8'h00;
         if (wd == 8'hC0 && (cyc - t_prog) < PW) wait_viol++;
         if (wd == 8'hA0) begin
            a0_cnt++;
            if ((cyc - t_erase) < EWT) wait_viol++;
         end
      end
   end

   // strobe monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (!fl_we_n) begin
            wl++;
            if (fl_ce_n || !fl_oe_n) strobe_bad++;
         end else if (wl != 0) begin
            if (wl != WE) strobe_bad++;
            wl = 0;
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clr_stats();
      prog_ops = 0; erase_ops = 0; a0_cnt = 0; ff_run = 0;
      fail_prog = 0; fail_erase = 0; bad_a = -1;
      wait_viol = 0; preprog_bad = 0; strobe_bad = 0;
   endtask

   task automatic fill(input logic [7:0] v);
      for (int i = 0; i < DEPTH; i++) mem[i] = v;
   endtask

   function automatic int count_not_blank();
      int n = 0;
      for (int i = 0; i < DEPTH; i++) if (mem[i] != 8'hFF) n++;
      return n;
   endfunction

   task automatic pulse_req(input bit p, input bit e, input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      req_prog = p; req_erase = e; req_addr = a; req_data = d;
      @(negedge clk);
      req_prog = 1'b0; req_erase = 1'b0;
   endtask

   task automatic wait_done(output bit e_seen);
      bit got = 1'b0;
      e_seen = 1'b0;
      for (int k = 0; k < 40000; k++) begin
         if (done) begin got = 1'b1; e_seen = err; break; end
         @(negedge clk);
      end
      chk(got, "R9 done reached", int'(got), 1);
      @(negedge clk);
      chk(!done, "R9 done one cycle", int'(done), 0);
      chk(ff_run >= 2, "R9 two FFh exit writes", ff_run, 2);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(fl_ce_n && fl_we_n && fl_oe_n, "R1 bus idle", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
      chk(!busy && !done && !err, "R1 status low", {busy, done, err}, 0);
   endtask

   task automatic t_prog_basic();
      bit e;
      clr_stats(); fill(8'hFF);
      pulse_req(1'b1, 1'b0, 4'd5, 8'h3C);
      wait_done(e);
      chk(mem[5] == 8'h3C, "R3 byte programmed", mem[5], 8'h3C);
      chk(prog_ops == 1, "R3 single program pulse", prog_ops, 1);
      chk(wait_viol == 0, "R3 program wait", wait_viol, 0);
      chk(!e, "R9 no err on success", e, 0);
      chk(strobe_bad == 0, "R2 strobe shape", strobe_bad, 0);
      chk(!busy, "R1 idle after op", busy, 0);
   endtask

   task automatic t_prog_retry();
      bit e;
      clr_stats(); fill(8'hFF); fail_prog = 2;
      pulse_req(1'b1, 1'b0, 4'd7, 8'hA5);
      wait_done(e);
      chk(prog_ops == 3, "R4 retries until match", prog_ops, 3);
      chk(mem[7] == 8'hA5, "R4 byte after retry", mem[7], 8'hA5);
      chk(!e, "R4 no err within limit", e, 0);
   endtask

   task automatic t_prog_fail();
      bit e;
      clr_stats(); fill(8'hFF); fail_prog = 1000;
      pulse_req(1'b1, 1'b0, 4'd1, 8'h00);
      wait_done(e);
      chk(prog_ops == PT, "R4 attempts capped", prog_ops, PT);
      chk(e, "R4 err on exhaustion", e, 1);
      fail_prog = 0;
   endtask

   task automatic t_erase_basic();
      bit e;
      clr_stats();
      for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i * 37 + 5);
      pulse_req(1'b0, 1'b1, '0, '0);
      wait_done(e);
      chk(preprog_bad == 0, "R5 all bytes 00h before erase", preprog_bad, 0);
      chk(prog_ops == DEPTH, "R5 one program per byte", prog_ops, DEPTH);
      chk(erase_ops == 1, "R6 single erase pulse", erase_ops, 1);
      chk(wait_viol == 0, "R6 erase wait", wait_viol, 0);
      chk(a0_cnt == DEPTH, "R7 one verify per address", a0_cnt, DEPTH);
      chk(count_not_blank() == 0, "R7 chip blank", count_not_blank(), 0);
      chk(!e, "R9 no err on clean erase", e, 0);
   endtask

   task automatic t_erase_retry();
      bit e;
      clr_stats(); fill(8'h5A); bad_a = 9; fail_erase = 1;
      pulse_req(1'b0, 1'b1, '0, '0);
      wait_done(e);
      chk(erase_ops == 2, "R8 second erase pulse", erase_ops, 2);
      chk(a0_cnt == DEPTH + 1, "R8 resume at failing addr", a0_cnt, DEPTH + 1);
      chk(count_not_blank() == 0, "R8 chip blank after retry", count_not_blank(), 0);
      chk(!e, "R8 no err within limit", e, 0);
   endtask

   task automatic t_erase_fail();
      bit e;
      clr_stats(); fill(8'hFF); bad_a = 3; fail_erase = 1000;
      pulse_req(1'b0, 1'b1, '0, '0);
      wait_done(e);
      chk(erase_ops == ET, "R8 erase pulses capped", erase_ops, ET);
      chk(e, "R8 err on exhaustion", e, 1);
      fail_erase = 0;
   endtask

   task automatic t_busy_ignore();
      bit e;
      clr_stats(); fill(8'hFF);
      pulse_req(1'b1, 1'b0, 4'd2, 8'h11);
      repeat (5) @(negedge clk);
      pulse_req(1'b1, 1'b1, 4'd3, 8'h00);
      wait_done(e);
      chk(erase_ops == 0, "R10 erase ignored while busy", erase_ops, 0);
      chk(mem[3] == 8'hFF, "R10 program ignored while busy", mem[3], 8'hFF);
      chk(mem[2] == 8'h11, "R10 first request done", mem[2], 8'h11);
      repeat (3) @(negedge clk);
      chk(!busy, "R10 no queued operation", busy, 0);
   endtask

   task automatic t_priority();
      bit e;
      clr_stats(); fill(8'hAB);
      pulse_req(1'b1, 1'b1, 4'd1, 8'h00);
      wait_done(e);
      chk(erase_ops == 1, "R10 erase wins", erase_ops, 1);
      chk(count_not_blank() == 0, "R10 chip erased", count_not_blank(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      fill(8'hFF);
      clr_stats();
      wl = 0; t_prog = 0; t_erase = 0;
      t_reset();
      t_prog_basic();
      t_prog_retry();
      t_prog_fail();
      t_erase_basic();
      t_erase_retry();
      t_erase_fail();
      t_busy_ignore();
      t_priority();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule